// File: doc/BRIEF.md
# Twin-Input Reversible Binary Counter

This block keeps a small binary count that moves up or down in response to two separate count strobes instead of one clock plus a direction bit. A rising edge on the up strobe advances the count only while the down strobe rests high. A rising edge on the down strobe retreats the count only while the up strobe rests high. Both strobes are sampled by one free-running system clock. Each passes through a synchronizer, and its rising edges are found synchronously, so the whole block is ordinary clocked logic.

A master clear and an active-low parallel load act on the count register at the system clock edge. Clear always wins over load. Two active-low terminal outputs follow the low phase of the matching strobe when the count sits at its limit. The carry output is low at the top value while the up strobe is low. The borrow output is low at zero while the down strobe is low. Wiring carry to the up strobe and borrow to the down strobe of the next copy builds a wider counter that ripples stage by stage.

Top module: `twin_clock_counter`

## Requirements
- R1: A synchronized rising edge on `cnt_up`, seen while the synchronized `cnt_dn` is high and without a simultaneous `cnt_dn` edge, raises `count` by one.
- R2: A synchronized rising edge on `cnt_dn`, seen while the synchronized `cnt_up` is high and without a simultaneous `cnt_up` edge, lowers `count` by one.
- R3: `carry_n` is 0 exactly in the cycle after a cycle in which `count` is all ones and the synchronized `cnt_up` is 0; otherwise it is 1.
- R4: `borrow_n` is 0 exactly in the cycle after a cycle in which `count` is zero and the synchronized `cnt_dn` is 0; otherwise it is 1.
- R5: While `load_n` is 0 and `clear` is 0, each clock edge copies `din` into `count`, and strobe edges have no effect.
- R6: While `clear` is 1, the next clock edge sets `count` to zero, whatever `load_n`, `din` and the strobes are doing.
- R7: A strobe that stays low through a clear or a load has its first rising edge after the release counted normally.
- R8: With one stage's `carry_n` wired to the next stage's `cnt_up` and its `borrow_n` wired to the next stage's `cnt_dn`, the pair counts as one wider binary counter in both directions.
- R9: Counting up from all ones gives zero, and counting down from zero gives all ones.
- R10: The count holds when both strobes show a rising edge in the same cycle, and when a strobe rises while the other strobe is low.
- R11: While `rst` is 1, the next edge sets `count` to zero and drives both `carry_n` and `borrow_n` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up | input | 1 | Up count strobe; a rising edge counts up |
| cnt_dn | input | 1 | Down count strobe; a rising edge counts down |
| load_n | input | 1 | Parallel load enable, active low |
| clear | input | 1 | Master clear, active high, wins over load |
| din | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count, registered |
| carry_n | output | 1 | Active-low up terminal output, registered |
| borrow_n | output | 1 | Active-low down terminal output, registered |

## Verification
The bench chains two 4-bit copies into an 8-bit counter. It walks them through single up and down steps and through wraps at both ends that ripple into the upper stage. These patterns show whether the terminal outputs really copy the strobe's low phase, because the upper nibble only moves when they do. It also tries edges on both strobes together and edges while the other strobe is held low; these show whether the hold rule is kept apart from normal counting. Strobes held low across a clear, across a clear combined with a load, and across a load show whether edges are dropped or counted at the correct moment relative to the release.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  // Decision taken each system clock about the count register.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

endpackage

// File: rtl/tcc_sync.sv
// Multi-flop synchronizer for one strobe; resets to the idle (high) level.
module tcc_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/tcc_edge.sv
// Rising-edge finder on an already synchronized level.
module tcc_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;

endmodule

// File: rtl/tcc_steer.sv
// Chooses increment, decrement or hold from the two strobe levels and edges.
module tcc_steer
  import tcc_pkg::*;
(
  input  logic  up_lvl,
  input  logic  dn_lvl,
  input  logic  up_rise,
  input  logic  dn_rise,
  output step_e step
);

  always_comb begin
    step = STEP_HOLD;
    // Only a lone edge with the opposite strobe parked high is a valid count.
    if (up_rise && !dn_rise && dn_lvl)      step = STEP_INC;
    else if (dn_rise && !up_rise && up_lvl) step = STEP_DEC;
  end

endmodule

// File: rtl/tcc_core.sv
// Count register with clear, load, stepping and registered terminal outputs.
module tcc_core
  import tcc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  step_e            step,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = ZERO;
    else if (!load_n) cnt_d = din;
    else begin
      case (step)
        STEP_INC: cnt_d = cnt_q + ONE;
        STEP_DEC: cnt_d = cnt_q - ONE;
        default:  cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ZERO;
    else     cnt_q <= cnt_d;
  end

  // Terminal outputs follow the strobe's low phase while the count sits at a limit.
  always_ff @(posedge clk) begin
    if (rst) begin
      carry_n  <= 1'b1;
      borrow_n <= 1'b1;
    end else begin
      carry_n  <= ~((cnt_q == TOP)  && !up_lvl);
      borrow_n <= ~((cnt_q == ZERO) && !dn_lvl);
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/twin_clock_counter.sv
module twin_clock_counter
  import tcc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             load_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  logic  up_lvl, dn_lvl;
  logic  up_rise, dn_rise;
  step_e step;

  tcc_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_up (
    .clk(clk), .rst(rst), .d(cnt_up), .q(up_lvl)
  );
  tcc_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_dn (
    .clk(clk), .rst(rst), .d(cnt_dn), .q(dn_lvl)
  );

  tcc_edge #(.IDLE(1'b1)) u_edge_up (
    .clk(clk), .rst(rst), .lvl(up_lvl), .rise(up_rise)
  );
  tcc_edge #(.IDLE(1'b1)) u_edge_dn (
    .clk(clk), .rst(rst), .lvl(dn_lvl), .rise(dn_rise)
  );

  tcc_steer u_steer (
    .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .up_rise(up_rise), .dn_rise(dn_rise),
    .step(step)
  );

  tcc_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .clear(clear), .load_n(load_n), .din(din),
    .step(step), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
  );

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_lvl,
  input logic             dn_lvl,
  input logic             up_rise,
  input logic             dn_rise
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0)); // R6

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load_n) |=> (count == $past(din))); // R5

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n) |=> ((count == $past(count)) ||
                            (count == WIDTH'($past(count) + 1'b1)) ||
                            (count == WIDTH'($past(count) - 1'b1)))); // R9

  AST_BOTH_EDGES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && up_rise && dn_rise) |=> $stable(count)); // R10

  AST_CARRY_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (($past(count) == TOP) && !$past(up_lvl))); // R3

  AST_BORROW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (($past(count) == '0) && !$past(dn_lvl))); // R4

endmodule

bind twin_clock_counter tcc_checker #(.WIDTH(WIDTH)) u_tcc_checker (
  .clk(clk), .rst(rst), .clear(clear), .load_n(load_n), .din(din),
  .count(count), .carry_n(carry_n), .borrow_n(borrow_n),
  .up_lvl(up_lvl), .dn_lvl(dn_lvl), .up_rise(up_rise), .dn_rise(dn_rise)
);

// File: tb/sim_twin_clock_counter.sv
module sim_twin_clock_counter;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 10;

  typedef struct packed {
    logic       up;
    logic       dn;
    logic       ldn;
    logic       clr;
    logic [7:0] data;
    logic [7:0] exp;
    logic       c;
    logic       b;
    logic [3:0] req;
  } vec_t;

  // Each row: drive levels, wait SETTLE cycles, then compare the 8-bit chain.
  localparam vec_t VEC [0:27] = '{
    '{1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,1'b1,1'b1,4'd3},  // R3 up low at zero, carry stays high
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h01,1'b1,1'b1,4'd1},  // R1
    '{1'b0,1'b1,1'b1,1'b0,8'h00,8'h01,1'b1,1'b1,4'd1},  // R1
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h02,1'b1,1'b1,4'd1},  // R1
    '{1'b1,1'b0,1'b1,1'b0,8'h00,8'h02,1'b1,1'b1,4'd2},  // R2
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h01,1'b1,1'b1,4'd2},  // R2
    '{1'b1,1'b0,1'b1,1'b0,8'h00,8'h01,1'b1,1'b1,4'd4},  // R4 not zero, borrow high
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,1'b1,1'b1,4'd2},  // R2
    '{1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,1'b1,1'b0,4'd4},  // R4 borrow low
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'hFF,1'b1,1'b1,4'd8},  // R8 R9 wrap down ripples
    '{1'b0,1'b1,1'b1,1'b0,8'h00,8'hFF,1'b0,1'b1,4'd3},  // R3 carry low
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,1'b1,1'b1,4'd9},  // R9 R8 wrap up ripples
    '{1'b1,1'b1,1'b0,1'b0,8'h35,8'h35,1'b1,1'b1,4'd5},  // R5
    '{1'b0,1'b0,1'b1,1'b0,8'h00,8'h35,1'b1,1'b1,4'd10}, // R10
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h35,1'b1,1'b1,4'd10}, // R10 both rise together
    '{1'b1,1'b0,1'b1,1'b0,8'h00,8'h35,1'b1,1'b1,4'd10}, // R10
    '{1'b0,1'b0,1'b1,1'b0,8'h00,8'h35,1'b1,1'b1,4'd10}, // R10
    '{1'b1,1'b0,1'b1,1'b0,8'h00,8'h35,1'b1,1'b1,4'd10}, // R10 up rises with down low
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h34,1'b1,1'b1,4'd2},  // R2
    '{1'b0,1'b1,1'b0,1'b1,8'hAA,8'h00,1'b1,1'b1,4'd6},  // R6 clear beats load
    '{1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,1'b1,1'b1,4'd7},  // R7
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h01,1'b1,1'b1,4'd7},  // R7 edge after clear counted
    '{1'b1,1'b1,1'b0,1'b0,8'hF0,8'hF0,1'b1,1'b1,4'd5},  // R5
    '{1'b0,1'b1,1'b0,1'b0,8'hF0,8'hF0,1'b1,1'b1,4'd5},  // R5
    '{1'b1,1'b1,1'b0,1'b0,8'hF0,8'hF0,1'b1,1'b1,4'd5},  // R5 edge during load ignored
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'hF0,1'b1,1'b1,4'd5},  // R5
    '{1'b1,1'b0,1'b1,1'b0,8'h00,8'hF0,1'b1,1'b0,4'd4},  // R4
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'hEF,1'b1,1'b1,4'd8}   // R8 borrow ripple
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up = 1'b1, dn = 1'b1, ldn = 1'b1, clr = 1'b0;
  logic [7:0] data = 8'h00;
  logic [3:0] cnt_lo, cnt_hi;
  logic       c_lo, b_lo, c_hi, b_hi;
  int         total = 0;
  int         bad = 0;
  int         cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_clock_counter #(.WIDTH(4), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cnt_up(up), .cnt_dn(dn), .load_n(ldn), .clear(clr),
    .din(data[3:0]), .count(cnt_lo), .carry_n(c_lo), .borrow_n(b_lo)
  );

  twin_clock_counter #(.WIDTH(4), .SYNC_STAGES(2)) u1 (
    .clk(clk), .rst(rst), .cnt_up(c_lo), .cnt_dn(b_lo), .load_n(ldn), .clear(clr),
    .din(data[7:4]), .count(cnt_hi), .carry_n(c_hi), .borrow_n(b_hi)
  );

  task automatic check(input int req, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_neg(4);
    rst = 1'b0;
    wait_neg(1);
    // R11 reset state
    check(11, "reset count", {cnt_hi, cnt_lo}, 8'h00);
    check(11, "reset carry_n", {7'd0, c_lo}, 8'h01);
    check(11, "reset borrow_n", {7'd0, b_lo}, 8'h01);

    for (int k = 0; k < 28; k++) begin
      up   = VEC[k].up;
      dn   = VEC[k].dn;
      ldn  = VEC[k].ldn;
      clr  = VEC[k].clr;
      data = VEC[k].data;
      wait_neg(SETTLE);
      check(int'(VEC[k].req), $sformatf("vec %0d count", k), {cnt_hi, cnt_lo}, VEC[k].exp);
      check(int'(VEC[k].req), $sformatf("vec %0d carry_n", k), {7'd0, c_lo}, {7'd0, VEC[k].c});
      check(int'(VEC[k].req), $sformatf("vec %0d borrow_n", k), {7'd0, b_lo}, {7'd0, VEC[k].b});
    end

    // R11 reset in the middle of a run, with strobes idle
    rst = 1'b1;
    wait_neg(2);
    check(11, "mid reset count", {cnt_hi, cnt_lo}, 8'h00);
    rst = 1'b0;
    wait_neg(2);

    // R3 load the top value while up is low: carry follows one cycle behind count
    up = 1'b0;
    wait_neg(SETTLE);
    data = 8'h0F;
    ldn  = 1'b0;
    wait_neg(1);
    check(5, "top load count", {cnt_hi, cnt_lo}, 8'h0F);
    check(3, "carry_n not yet low", {7'd0, c_lo}, 8'h01);
    wait_neg(1);
    check(3, "carry_n low after top", {7'd0, c_lo}, 8'h00);
    ldn = 1'b1;
    up  = 1'b1;
    wait_neg(SETTLE);
    check(8, "carry ripple into upper", {cnt_hi, cnt_lo}, 8'h10);
    check(3, "carry_n back high", {7'd0, c_lo}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule